// File: doc/BRIEF.md
# Tree Priority Encoder

This block takes an N-bit request vector and returns the binary position of the highest-numbered set bit, together with a flag that says whether any bit was set. Bit N-1 has the highest priority and bit 0 the lowest. The block suits arbitration, interrupt selection and leading-one detection wherever a plain priority chain would be too deep.

The encoder is a tree of radix-K nodes, with K = 4 by default. Each node looks at K child flags and finds the highest child that is active. It then prepends that child's number to the child's own partial index. The tree has ceil(log_K N) levels. When N is not a power of K, the input is padded at the top with zeros.

A parameter chooses between two forms. In one form the tree is purely combinational. In the other, every level is followed by a register. The registered form has a synchronous reset and accepts a new vector every cycle.

Top module: `tree_prio_enc`

## Requirements
- R1: When at least one request bit is set, `idx` equals the position of the highest-numbered set bit. Position 0 is `req[0]`.
- R2: `hit` is 1 when any request bit is set and 0 when none is set.
- R3: With an all-zero request, `idx` is 0 and `hit` is 0.
- R4: When several bits are set, all bits below the highest one are ignored. They have no effect on `idx` or `hit`.
- R5: `idx` is $clog2(N) bits wide. For an N that is not a power of K, the index always lies below N and the padding bits never win.
- R6: With PIPE = 1, the result for a vector appears after exactly ceil(log_K N) clock cycles, and a new vector may be applied every cycle. For K = 4 that is 2 cycles at N = 16 and 3 cycles at N = 64.
- R7: With PIPE = 1, a cycle with `rst` high clears every level register. In the following cycle `hit` is 0 and `idx` is 0.
- R8: With PIPE = 0, the outputs follow `req` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the level registers and the checks |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N | Request vector; the highest-numbered bit has the highest priority |
| idx | output | $clog2(N) | Position of the winning request |
| hit | output | 1 | At least one request was set |

## Verification
The same-cycle assertions assume that `req` is settled at every rising clock edge and stays constant between edges. The bench meets this by changing inputs only on falling edges. The registered form is checked against its reset behaviour and its output range only. The assertions do not relate inputs to outputs across the pipeline, so they take nothing for granted about the input sequence. The stimulus gives the 16-bit form every possible vector. The 64-bit and 20-bit forms receive a mix of zero, one-hot, dense and sparse random vectors, so both ends of the priority order are reached.

// File: rtl/tree_prio_enc.sv
module tree_prio_enc #(
  parameter int N = 16,
  parameter int K = 4,
  parameter bit PIPE = 1'b0,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          hit
);
  localparam int LOGK   = $clog2(K);
  localparam int LEVELS = (IW + LOGK - 1) / LOGK;
  localparam int FW     = LEVELS * LOGK;
  localparam int PADW   = 1 << FW;

  logic          lv_v [LEVELS+1][PADW];
  logic [FW-1:0] lv_i [LEVELS+1][PADW];

  function automatic logic [FW:0] merge(input logic [K-1:0] cv,
                                        input logic [K*FW-1:0] ci,
                                        input int sh);
    logic [FW-1:0] low, hi;
    logic any;
    low = '0;
    hi  = '0;
    any = 1'b0;
    for (int c = 0; c < K; c++) begin
      if (cv[c]) begin
        any = 1'b1;
        hi  = FW'(c);
        low = ci[c*FW +: FW];
      end
    end
    return {any, (hi << sh) | low};
  endfunction

  for (genvar b = 0; b < PADW; b++) begin : g_leaf
    if (b < N) begin : g_in
      assign lv_v[0][b] = req[b];
    end else begin : g_pad
      assign lv_v[0][b] = 1'b0;
    end
    assign lv_i[0][b] = '0;
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NODES = PADW >> (LOGK * (l + 1));
    for (genvar j = 0; j < PADW; j++) begin : g_node
      if (j < NODES) begin : g_live
        logic [K-1:0]    cv;
        logic [K*FW-1:0] ci;
        logic [FW:0]     m;
        for (genvar c = 0; c < K; c++) begin : g_ch
          assign cv[c]            = lv_v[l][j*K+c];
          assign ci[c*FW +: FW]   = lv_i[l][j*K+c];
        end
        assign m = merge(cv, ci, l * LOGK);
        if (PIPE) begin : g_reg
          always_ff @(posedge clk) begin
            if (rst) begin
              lv_v[l+1][j] <= 1'b0;
              lv_i[l+1][j] <= '0;
            end else begin
              lv_v[l+1][j] <= m[FW];
              lv_i[l+1][j] <= m[FW-1:0];
            end
          end
        end else begin : g_comb
          assign lv_v[l+1][j] = m[FW];
          assign lv_i[l+1][j] = m[FW-1:0];
        end
      end else begin : g_idle
        assign lv_v[l+1][j] = 1'b0;
        assign lv_i[l+1][j] = '0;
      end
    end
  end

  assign hit = lv_v[LEVELS][0];
  assign idx = lv_i[LEVELS][0][IW-1:0];

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> idx == '0);

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> int'(idx) < N);

  if (PIPE) begin : g_pipe_chk
    // R7
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!hit && idx == '0));
  end else begin : g_comb_chk
    // R1
    top_bit_chk: assert property (@(posedge clk) disable iff (rst)
      hit |-> (req >> idx) == N'(1));
    // R2
    any_req_chk: assert property (@(posedge clk) disable iff (rst)
      hit == (|req));
  end
endmodule

// File: tb/tree_prio_enc_test.sv
`timescale 1ns/1ps
module tree_prio_enc_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] r16 = '0;
  logic [63:0] r64 = '0;
  logic [19:0] r20 = '0;
  logic [3:0] i16;
  logic [5:0] i64;
  logic [4:0] i20;
  logic h16, h64, h20;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  int hv [3];
  int hi [3];

  always #2 clk = ~clk;

  tree_prio_enc #(.N(16)) uut (.clk(clk), .rst(rst), .req(r16), .idx(i16), .hit(h16));
  tree_prio_enc #(.N(64), .PIPE(1'b1)) uut_pipe (.clk(clk), .rst(rst), .req(r64), .idx(i64), .hit(h64));
  tree_prio_enc #(.N(20)) uut_odd (.clk(clk), .rst(rst), .req(r20), .idx(i20), .hit(h20));

  function automatic int ref_pe(logic [63:0] v, int n);
    for (int i = n - 1; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(string tag, int av, int ai, int ev, int ei);
    total++;
    if (av != ev || ai != ei) begin
      fails++;
      $display("FAIL %s: hit=%0d idx=%0d expected hit=%0d idx=%0d", tag, av, ai, ev, ei);
    end
  endtask

  function automatic logic [63:0] pick64();
    case ($urandom % 4)
      0: return '0;
      1: return 64'(1) << ($urandom % 64);
      2: return {$urandom, $urandom};
      default: return {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
    endcase
  endfunction

  task automatic push(int r);
    hv[2] = hv[1]; hi[2] = hi[1];
    hv[1] = hv[0]; hi[1] = hi[0];
    hv[0] = (r >= 0) ? 1 : 0;
    hi[0] = (r >= 0) ? r : 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog: hit=0 idx=0 expected hit=1 idx=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int r;
    logic [63:0] v;
    void'($urandom(32'd4711));
    for (int k = 0; k < 3; k++) begin hv[k] = 0; hi[k] = 0; end
    repeat (3) @(negedge clk);
    // R7 reset state of the registered form; R3 on the idle combinational forms
    chk("R7", int'(h64), int'(i64), 0, 0);
    chk("R3", int'(h16), int'(i16), 0, 0);
    chk("R3", int'(h20), int'(i20), 0, 0);
    rst = 1'b0;

    for (int e = 0; e < 65536; e++) begin
      @(negedge clk);
      if (e == 30001) chk("R7", int'(h64), int'(i64), 0, 0);
      else chk("R6", int'(h64), int'(i64), hv[2], hi[2]);
      rst = (e == 30000);
      v = pick64();
      r64 = v;
      push(ref_pe(v, 64));
      if (e == 30000) for (int k = 0; k < 3; k++) begin hv[k] = 0; hi[k] = 0; end
      r16 = 16'(e);
      r20 = 20'(pick64());
      #1;
      if (e != 30000) begin
        r = ref_pe(64'(r16), 16);
        chk(e == 0 ? "R3" : ($countones(r16) > 1 ? "R4" : "R1"),
            int'(h16), int'(i16), r >= 0 ? 1 : 0, r >= 0 ? r : 0);
        chk("R2", int'(h16), 0, r16 != 0 ? 1 : 0, 0);
        r = ref_pe(64'(r20), 20);
        chk("R5", int'(h20), int'(i20), r >= 0 ? 1 : 0, r >= 0 ? r : 0);
      end
    end

    // R5 padding never wins; the top real bit does
    @(negedge clk);
    r20 = 20'h80000; #1;
    chk("R5", int'(h20), int'(i20), 1, 19);
    r20 = 20'h00001; #1;
    chk("R5", int'(h20), int'(i20), 1, 0);
    // R4 low bits ignored: every bit set still yields the top position
    r16 = 16'hFFFF; #1;
    chk("R4", int'(h16), int'(i16), 1, 15);
    // R8 outputs follow the input with no clock edge in between
    r16 = 16'h0024; #0.5;
    chk("R8", int'(h16), int'(i16), 1, 5);
    r16 = 16'h0000; #0.5;
    chk("R8", int'(h16), int'(i16), 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule